// File: doc/BRIEF.md
# UART Host Register Interface

This block is the register file that a host processor sees in front of a UART. Twelve 16-bit registers sit in a small address window. Each register takes a 4-byte slot. The block holds the baud divisor, global, line and modem control, and a scratch word. It keeps an interrupt-enable word that the host changes only through separate set and clear aliases. It also holds the sticky error flags of the line status register and the clear-to-send-changed flag of the modem status register. The host clears these flags by writing ones.

The serial shifter, the baud generator and the receive queue live outside the block. A legal write of the transmit holding slot hands the byte to the transmitter with a one-cycle push strobe. A legal read of the receive buffer slot pops the receiver with a one-cycle strobe and returns the byte it offered. Reading line status merges the live data-ready and transmitter-empty bits into the returned value. Accesses that are not 16 bits wide, or that fall outside the map, raise a one-cycle error flag and change nothing.

Top module: `uart_mmr_core`

## Requirements
- R1: After reset the divisor-low register reads 0x0001 and every other stored register reads 0x0000. Line status reads 0x0060 while the transmitter reports holding-empty and shifter-empty and no data is ready.
- R2: The register index is the byte offset divided by 4, in this order: 0 divisor low, 1 divisor high, 2 global control, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch, 8 enable-set, 9 enable-clear, 10 transmit holding, 11 receive buffer. Indexes 0–4 and 7 store all 16 written bits and read them back.
- R3: Size code 01 (16 bits) at an even address is the only legal access. Codes 00 (8 bits), 10 (32 bits) and 11, or an odd address, raise `bus_err_size` in the cycle after the request. In that case `bus_err_map` stays low, even if the offset is also unmapped.
- R4: A correctly sized access whose offset has bit 1 set or whose index is above 11 raises `bus_err_map` in the next cycle. Any bad access leaves all registers unchanged, raises no strobe and returns read data 0.
- R5: A write to enable-set ORs the written value into the enable word.
- R6: A write to enable-clear clears each enable bit that is written as 1. A read of either alias returns the enable word.
- R7: The line status layout is DR=bit0, OE=bit1, PE=bit2, FE=bit3, BI=bit4, THRE=bit5, TEMT=bit6, TFI=bit7. Event input `line_evt` bits 0..4 (OE, PE, FE, BI, TFI) set the sticky flags. Writing 1 clears only OE, PE, FE, BI and TFI, and an event in the same cycle wins over the clear.
- R8: Modem status bit 0 is set by `cts_evt`. A 1 written to bit 0 clears it, and writes to other bits have no effect. Bits 15..1 read 0.
- R9: A line status read returns DR, THRE and TEMT as sampled from the live inputs in the request cycle.
- R10: A write to the receive buffer has no effect and raises no pop. A read drives `rx_pop` high in the request cycle and returns `rx_data` zero-extended.
- R11: A legal transmit-holding write drives `tx_push` for that cycle with `tx_data` equal to the low byte of the write data. Reading that slot returns the last byte written. `tx_event` accompanies the push when enable bit 1 is set.
- R12: Read data is registered: it appears in the cycle after a legal read and is 0x0000 in every other cycle. A simultaneous read and write is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset inside the window |
| bus_size | input | 2 | Access size code: 00 byte, 01 half, 10 word |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_err_size | output | 1 | One-cycle flag for an illegal access size or odd address |
| bus_err_map | output | 1 | One-cycle flag for an unmapped offset |
| tx_push | output | 1 | Transmit holding write strobe |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_event | output | 1 | Transmit request pulse when enable bit 1 is set |
| rx_pop | output | 1 | Receive buffer read strobe |
| rx_data | input | 8 | Byte offered by the receiver |
| live_dr | input | 1 | Live data-ready status |
| live_thre | input | 1 | Live holding-empty status |
| live_temt | input | 1 | Live shifter-empty status |
| line_evt | input | 5 | Sticky flag set pulses: OE, PE, FE, BI, TFI |
| cts_evt | input | 1 | Clear-to-send change pulse |

## Verification
The strobes `tx_push`, `tx_event`, `rx_pop` and `tx_data` are combinational in the request cycle. The bench samples them one nanosecond after it drives the inputs on the falling edge. Read data and both error flags are registered, so they come one rising edge later. The bench samples them one nanosecond after that edge. Register updates and sticky flag events take effect at the same edge. The bench model applies them there, so the next access sees the new state. Each expected value is computed before the edge from the model state as it stood before that edge.

// File: rtl/uart_mmr_pkg.sv
package uart_mmr_pkg;

    localparam int DATA_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int NUM_REGS   = 12;
    localparam int IDX_W      = $clog2(NUM_REGS);
    localparam int SLOT_SHIFT = 2;
    localparam int STICKY_N   = 5;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

    // line status bit positions
    localparam int LS_DR   = 0;
    localparam int LS_OE   = 1;
    localparam int LS_PE   = 2;
    localparam int LS_FE   = 3;
    localparam int LS_BI   = 4;
    localparam int LS_THRE = 5;
    localparam int LS_TEMT = 6;
    localparam int LS_TFI  = 7;

    localparam int EN_TX_BIT  = 1;
    localparam int MS_CTS_CHG = 0;

    typedef enum logic [IDX_W-1:0] {
        RG_DIV_LO     = 4'd0,
        RG_DIV_HI     = 4'd1,
        RG_GCTL       = 4'd2,
        RG_LINE_CTL   = 4'd3,
        RG_MODEM_CTL  = 4'd4,
        RG_LINE_STAT  = 4'd5,
        RG_MODEM_STAT = 4'd6,
        RG_SCRATCH    = 4'd7,
        RG_EN_SET     = 4'd8,
        RG_EN_CLR     = 4'd9,
        RG_TX_HOLD    = 4'd10,
        RG_RX_BUF     = 4'd11
    } reg_e;

    typedef struct packed {
        logic wr;
        logic rd;
        logic err_size;
        logic err_map;
        reg_e idx;
    } req_t;

    function automatic logic is_plain(int i);
        return (i == int'(RG_DIV_LO))    || (i == int'(RG_DIV_HI)) ||
               (i == int'(RG_GCTL))      || (i == int'(RG_LINE_CTL)) ||
               (i == int'(RG_MODEM_CTL)) || (i == int'(RG_SCRATCH));
    endfunction

    function automatic logic [DATA_W-1:0] plain_reset(int i);
        return (i == int'(RG_DIV_LO)) ? DATA_W'(1) : '0;
    endfunction

    // sticky vector order: [0]=OE [1]=PE [2]=FE [3]=BI [4]=TFI
    function automatic logic [DATA_W-1:0] lsr_merge(logic [STICKY_N-1:0] s,
                                                   logic dr, logic thre, logic temt);
        logic [DATA_W-1:0] v;
        v          = '0;
        v[LS_DR]   = dr;
        v[LS_OE]   = s[0];
        v[LS_PE]   = s[1];
        v[LS_FE]   = s[2];
        v[LS_BI]   = s[3];
        v[LS_THRE] = thre;
        v[LS_TEMT] = temt;
        v[LS_TFI]  = s[4];
        return v;
    endfunction

    function automatic logic [STICKY_N-1:0] lsr_clear_mask(logic [DATA_W-1:0] d);
        return {d[LS_TFI], d[LS_BI], d[LS_FE], d[LS_PE], d[LS_OE]};
    endfunction

endpackage

// File: rtl/uart_mmr_decode.sv
module uart_mmr_decode
    import uart_mmr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output req_t              req
);
    localparam int SLOT_W = ADDR_W - SLOT_SHIFT;

    logic              active;
    logic              size_ok;
    logic              map_ok;
    logic [SLOT_W-1:0] slot;

    always_comb begin
        active  = wr | rd;
        slot    = addr[ADDR_W-1:SLOT_SHIFT];
        size_ok = (size == SZ_HALF) && !addr[0];
        map_ok  = !addr[1] && (int'(slot) < NUM_REGS);

        req.wr       = active && size_ok && map_ok && wr;
        req.rd       = active && size_ok && map_ok && !wr;
        req.err_size = active && !size_ok;
        req.err_map  = active && size_ok && !map_ok;
        req.idx      = map_ok ? reg_e'(slot[IDX_W-1:0]) : RG_DIV_LO;
    end
endmodule

// File: rtl/uart_mmr_ctrl.sv
module uart_mmr_ctrl
    import uart_mmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_e              wr_idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] plain_q [NUM_REGS],
    output logic [DATA_W-1:0] en_q,
    output logic [BYTE_W-1:0] hold_q
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        localparam reg_e SLOT = reg_e'(i);
        if (is_plain(i)) begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= plain_reset(i);
                else if (wr_en && wr_idx == SLOT)
                    q <= wdata;
            end
            assign plain_q[i] = q;
        end else begin : g_none
            assign plain_q[i] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            hold_q <= '0;
        end else if (wr_en) begin
            case (wr_idx)
                RG_EN_SET:  en_q   <= en_q | wdata;
                RG_EN_CLR:  en_q   <= en_q & ~wdata;
                RG_TX_HOLD: hold_q <= wdata[BYTE_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/uart_mmr_status.sv
module uart_mmr_status
    import uart_mmr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [STICKY_N-1:0] line_clr,
    input  logic                cts_clr,
    input  logic [STICKY_N-1:0] line_evt,
    input  logic                cts_evt,
    output logic [STICKY_N-1:0] sticky_q,
    output logic                cts_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_q <= '0;
            cts_q    <= 1'b0;
        end else begin
            // a new event outranks a clear in the same cycle
            sticky_q <= (sticky_q & ~line_clr) | line_evt;
            cts_q    <= (cts_q & ~cts_clr) | cts_evt;
        end
    end
endmodule

// File: rtl/uart_mmr_core.sv
module uart_mmr_core
    import uart_mmr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [1:0]          bus_size,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_err_size,
    output logic                bus_err_map,
    output logic                tx_push,
    output logic [BYTE_W-1:0]   tx_data,
    output logic                tx_event,
    output logic                rx_pop,
    input  logic [BYTE_W-1:0]   rx_data,
    input  logic                live_dr,
    input  logic                live_thre,
    input  logic                live_temt,
    input  logic [STICKY_N-1:0] line_evt,
    input  logic                cts_evt
);
    req_t                req;
    logic [DATA_W-1:0]   plain_q [NUM_REGS];
    logic [DATA_W-1:0]   en_q;
    logic [BYTE_W-1:0]   hold_q;
    logic [STICKY_N-1:0] sticky_q;
    logic                cts_q;
    logic [STICKY_N-1:0] line_clr;
    logic                cts_clr;
    logic [DATA_W-1:0]   rd_val;

    uart_mmr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr   (bus_wr),
        .rd   (bus_rd),
        .addr (bus_addr),
        .size (bus_size),
        .req  (req)
    );

    uart_mmr_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (req.wr),
        .wr_idx  (req.idx),
        .wdata   (bus_wdata),
        .plain_q (plain_q),
        .en_q    (en_q),
        .hold_q  (hold_q)
    );

    always_comb begin
        line_clr = (req.wr && req.idx == RG_LINE_STAT) ? lsr_clear_mask(bus_wdata) : '0;
        cts_clr  = req.wr && req.idx == RG_MODEM_STAT && bus_wdata[MS_CTS_CHG];
    end

    uart_mmr_status u_status (
        .clk      (clk),
        .rst      (rst),
        .line_clr (line_clr),
        .cts_clr  (cts_clr),
        .line_evt (line_evt),
        .cts_evt  (cts_evt),
        .sticky_q (sticky_q),
        .cts_q    (cts_q)
    );

    // strobes toward the transceiver, valid in the request cycle
    always_comb begin
        tx_push  = req.wr && req.idx == RG_TX_HOLD;
        tx_data  = bus_wdata[BYTE_W-1:0];
        tx_event = tx_push && en_q[EN_TX_BIT];
        rx_pop   = req.rd && req.idx == RG_RX_BUF;
    end

    always_comb begin
        case (req.idx)
            RG_LINE_STAT:  rd_val = lsr_merge(sticky_q, live_dr, live_thre, live_temt);
            RG_MODEM_STAT: rd_val = DATA_W'(cts_q);
            RG_EN_SET,
            RG_EN_CLR:     rd_val = en_q;
            RG_TX_HOLD:    rd_val = DATA_W'(hold_q);
            RG_RX_BUF:     rd_val = DATA_W'(rx_data);
            default:       rd_val = plain_q[req.idx];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata    <= '0;
            bus_err_size <= 1'b0;
            bus_err_map  <= 1'b0;
        end else begin
            bus_rdata    <= req.rd ? rd_val : '0;
            bus_err_size <= req.err_size;
            bus_err_map  <= req.err_map;
        end
    end
endmodule

// File: rtl/uart_mmr_core_chk.sv
module uart_mmr_core_chk
    import uart_mmr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [1:0]          bus_size,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                bus_err_size,
    input logic                bus_err_map,
    input logic                tx_push,
    input logic                tx_event,
    input logic                rx_pop,
    input logic                live_dr,
    input logic                live_thre,
    input logic                live_temt
);
    localparam logic [ADDR_W-1:0] OFF_LSR = ADDR_W'(int'(RG_LINE_STAT) * 4);
    localparam logic [ADDR_W-1:0] OFF_RBR = ADDR_W'(int'(RG_RX_BUF) * 4);

    a_r3_size_outranks_map: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && bus_size != SZ_HALF) |=> (bus_err_size && !bus_err_map));

    a_r4_single_error_kind: assert property (@(posedge clk) disable iff (rst)
        !(bus_err_size && bus_err_map));

    a_r9_live_bits_read: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_size == SZ_HALF && bus_addr == OFF_LSR) |=>
        (bus_rdata[LS_DR] == $past(live_dr) && bus_rdata[LS_THRE] == $past(live_thre) &&
         bus_rdata[LS_TEMT] == $past(live_temt)));

    a_r10_pop_only_on_read: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> (bus_rd && !bus_wr && bus_size == SZ_HALF && bus_addr == OFF_RBR));

    a_r11_event_with_push: assert property (@(posedge clk) disable iff (rst)
        tx_event |-> tx_push);

    a_r12_idle_rdata_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> bus_rdata == '0);
endmodule

bind uart_mmr_core uart_mmr_core_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/uart_mmr_core_bench.sv
`timescale 1ns/1ps
module uart_mmr_core_bench;
    import uart_mmr_pkg::*;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_size = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic          bus_err_size, bus_err_map;
    logic          tx_push, tx_event, rx_pop;
    logic [7:0]    tx_data;
    logic [7:0]    rx_data = '0;
    logic          live_dr = 1'b0, live_thre = 1'b1, live_temt = 1'b1;
    logic [4:0]    line_evt = '0;
    logic          cts_evt = 1'b0;

    int n_checks = 0;
    int n_err    = 0;

    logic [15:0] m_plain [12];
    logic [15:0] m_en;
    logic [7:0]  m_hold;
    logic [4:0]  m_sticky;
    logic        m_cts;

    always #2.5 clk = ~clk;

    uart_mmr_core #(.ADDR_W(AW)) u_uart_mmr_core (.*);

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    function automatic logic [15:0] model_read(int idx);
        case (idx)
            0, 1, 2, 3, 4, 7: return m_plain[idx];
            5:  return {8'h00, m_sticky[4], live_temt, live_thre, m_sticky[3],
                        m_sticky[2], m_sticky[1], m_sticky[0], live_dr};
            6:  return {15'b0, m_cts};
            8, 9: return m_en;
            10: return {8'h00, m_hold};
            11: return {8'h00, rx_data};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic access(bit w, bit r, logic [AW-1:0] a, logic [1:0] sz,
                          logic [15:0] d, string tag);
        bit          e_size, e_map, legal, e_push, e_event, e_pop;
        int          idx;
        logic [15:0] e_rd;
        logic [4:0]  clr;
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_size = sz; bus_wdata = d;
        idx     = int'(a[AW-1:2]);
        e_size  = (w || r) && !(sz == 2'b01 && !a[0]);
        e_map   = (w || r) && !e_size && (a[1] || idx >= 12);
        legal   = (w || r) && !e_size && !e_map;
        e_push  = legal && w && idx == 10;
        e_event = e_push && m_en[1];
        e_pop   = legal && !w && idx == 11;
        e_rd    = (legal && !w) ? model_read(idx) : 16'h0000;
        #1;
        chk({tag, " push"},  16'(tx_push),  16'(e_push));
        chk({tag, " event"}, 16'(tx_event), 16'(e_event));
        chk({tag, " pop"},   16'(rx_pop),   16'(e_pop));
        if (e_push) chk({tag, " tx_data"}, 16'(tx_data), {8'h00, d[7:0]});
        @(posedge clk);
        clr = '0;
        if (legal && w) begin
            case (idx)
                0, 1, 2, 3, 4, 7: m_plain[idx] = d;
                5:  clr = {d[7], d[4], d[3], d[2], d[1]};
                6:  m_cts = m_cts & ~d[0];
                8:  m_en = m_en | d;
                9:  m_en = m_en & ~d;
                10: m_hold = d[7:0];
                default: ;
            endcase
        end
        m_sticky = (m_sticky & ~clr) | line_evt;
        m_cts    = m_cts | cts_evt;
        #1;
        chk({tag, " rdata"},    bus_rdata,           e_rd);
        chk({tag, " err_size"}, 16'(bus_err_size),  16'(e_size));
        chk({tag, " err_map"},  16'(bus_err_map),   16'(e_map));
        bus_wr = 1'b0; bus_rd = 1'b0;
        line_evt = '0; cts_evt = 1'b0;
    endtask

    task automatic read_all(string tag);
        for (int i = 0; i < 12; i++) access(0, 1, AW'(i * 4), 2'b01, 16'h0, tag);
    endtask

    initial begin
        #1_000_000;
        n_checks++; n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 12; i++) m_plain[i] = (i == 0) ? 16'h0001 : 16'h0000;
        m_en = '0; m_hold = '0; m_sticky = '0; m_cts = 1'b0;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 reset rdata", bus_rdata, 16'h0);
        chk("R12 reset err", 16'({bus_err_size, bus_err_map}), 16'h0);
        // R1: reset values, LSR reads 0x0060 with transmitter idle
        read_all("R1 reset");
        access(0, 1, 6'h14, 2'b01, 16'h0, "R1 lsr");
        // R2: plain register storage at their slots
        access(1, 0, 6'h00, 2'b01, 16'hA5C3, "R2 dll");
        access(1, 0, 6'h04, 2'b01, 16'h1234, "R2 dlh");
        access(1, 0, 6'h08, 2'b01, 16'hFFFF, "R2 gctl");
        access(1, 0, 6'h0C, 2'b01, 16'h00FF, "R2 lcr");
        access(1, 0, 6'h10, 2'b01, 16'h8001, "R2 mcr");
        access(1, 0, 6'h1C, 2'b01, 16'h5A5A, "R2 scr");
        read_all("R2 readback");
        // R5 / R6: enable set and clear aliases
        access(1, 0, 6'h20, 2'b01, 16'h00F0, "R5 set");
        access(1, 0, 6'h20, 2'b01, 16'h000F, "R5 set");
        access(0, 1, 6'h20, 2'b01, 16'h0, "R5 read set");
        access(1, 0, 6'h24, 2'b01, 16'h0033, "R6 clear");
        access(0, 1, 6'h24, 2'b01, 16'h0, "R6 read clr");
        access(0, 1, 6'h20, 2'b01, 16'h0, "R6 read set");
        // R11: push without then with the transmit enable
        access(1, 0, 6'h28, 2'b01, 16'hBE41, "R11 push no en");
        access(1, 0, 6'h20, 2'b01, 16'h0002, "R11 enable");
        access(1, 0, 6'h28, 2'b01, 16'h0077, "R11 push en");
        access(0, 1, 6'h28, 2'b01, 16'h0, "R11 hold read");
        // R12: read and write together act as write
        access(1, 1, 6'h1C, 2'b01, 16'h0F0F, "R12 rd+wr");
        // R7: sticky flags
        line_evt = 5'b11111;
        access(0, 1, 6'h1C, 2'b01, 16'h0, "R7 evt");
        access(0, 1, 6'h14, 2'b01, 16'h0, "R7 all set");
        access(1, 0, 6'h14, 2'b01, 16'hFF67, "R7 w1c oe pe");
        access(0, 1, 6'h14, 2'b01, 16'h0, "R7 after clr");
        line_evt = 5'b10000;
        access(1, 0, 6'h14, 2'b01, 16'h0080, "R7 set wins");
        access(0, 1, 6'h14, 2'b01, 16'h0, "R7 tfi kept");
        access(1, 0, 6'h14, 2'b01, 16'hFFFF, "R7 clear all");
        // R9: live bits
        live_dr = 1'b1; live_thre = 1'b0; live_temt = 1'b0;
        access(0, 1, 6'h14, 2'b01, 16'h0, "R9 live");
        live_dr = 1'b0; live_thre = 1'b1; live_temt = 1'b0;
        access(0, 1, 6'h14, 2'b01, 16'h0, "R9 live");
        // R8: modem status flag
        cts_evt = 1'b1;
        access(0, 1, 6'h18, 2'b01, 16'h0, "R8 evt");
        access(0, 1, 6'h18, 2'b01, 16'h0, "R8 set");
        access(1, 0, 6'h18, 2'b01, 16'hFFFE, "R8 no clr");
        access(0, 1, 6'h18, 2'b01, 16'h0, "R8 kept");
        access(1, 0, 6'h18, 2'b01, 16'h0001, "R8 clr");
        access(0, 1, 6'h18, 2'b01, 16'h0, "R8 cleared");
        // R10: receive buffer
        rx_data = 8'hA5;
        access(1, 0, 6'h2C, 2'b01, 16'hFFFF, "R10 write ignored");
        access(0, 1, 6'h2C, 2'b01, 16'h0, "R10 pop");
        // R3 / R4: bad accesses change nothing
        access(1, 0, 6'h00, 2'b00, 16'h1111, "R3 byte");
        access(1, 0, 6'h04, 2'b10, 16'h2222, "R3 word");
        access(1, 0, 6'h09, 2'b01, 16'h3333, "R3 odd");
        access(1, 0, 6'h30, 2'b00, 16'h4444, "R3 priority");
        access(0, 1, 6'h2C, 2'b11, 16'h0, "R3 rx size");
        access(1, 0, 6'h30, 2'b01, 16'h5555, "R4 above");
        access(1, 0, 6'h06, 2'b01, 16'h6666, "R4 bit1");
        access(1, 0, 6'h2A, 2'b01, 16'h7777, "R4 hold bit1");
        access(0, 1, 6'h3C, 2'b01, 16'h0, "R4 read above");
        read_all("R4 unchanged");
        // random mix against the model
        for (int n = 0; n < 400; n++) begin
            bit          w;
            logic [AW-1:0] a;
            logic [1:0]  sz;
            w  = ($urandom % 2) == 1;
            a  = AW'($urandom % 64);
            if (($urandom % 4) != 0) a[1:0] = 2'b00;
            sz = (($urandom % 5) == 0) ? 2'($urandom % 4) : 2'b01;
            live_dr = 1'($urandom); live_thre = 1'($urandom); live_temt = 1'($urandom);
            rx_data = 8'($urandom);
            if (($urandom % 6) == 0) line_evt = 5'($urandom);
            if (($urandom % 8) == 0) cts_evt = 1'b1;
            access(w, !w || (($urandom % 3) == 0), a, sz, 16'($urandom), "R2-R12 random");
        end
        read_all("R2 final");
        finish_run();
    end
endmodule